// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a simple register bus behind a single 32-bit control/status word. A reference clock feeds a prescaler with four selectable divide ratios. Each prescaled tick advances an up-counter. When the count reaches the selected interval, an interrupt flag is raised, and the interrupt line follows it when interrupts are enabled. A fixed number of further ticks later, a reset flag is raised and a fixed-length reset request pulse is issued, but only when resets are enabled.

Software arms the timer through the control word. It can pause the count without losing it and resume it later. Writing the restart bit zeroes the count and the prescaler. Writing ones to the status flags clears them. The reset flag survives the system reset that the watchdog itself requests, so software can see after the restart why it happened. Only the power-on reset input clears it.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the control word at byte offset 0x1c reads 0x0000_0400, and irq and rst_req are low. Reads at any other offset return 0, and writes at any other offset change nothing.
- R2: Control word layout: clock select at [11:10], enable at bit 7, interrupt enable at bit 6, interval select at [5:4], interrupt flag at bit 3, reset flag at bit 2, reset enable at bit 1, restart at bit 0. The restart bit and all undefined bits read 0.
- R3: With clock select c and interval select s, the interrupt flag sets exactly 2^(INT_BASE_LOG2+INT_STEP_LOG2*s) * 2^DIVc_LOG2 enabled clock cycles after the write that arms the timer, and it is still clear one cycle earlier.
- R4: irq is high exactly when the interrupt flag and interrupt enable are both set. The flag sets at timeout even when interrupt enable is clear.
- R5: RST_DELAY prescaled ticks after the interrupt timeout, if reset enable is set, the reset flag sets and rst_req rises on the same cycle. If reset enable is clear, neither happens.
- R6: rst_req stays high for exactly RST_PULSE clock cycles.
- R7: While enable is clear, the counter and prescaler hold their values. After enable is set again, the remaining time to the interrupt equals what was left before the pause.
- R8: Writing 1 to the interrupt flag bit or the reset flag bit clears that flag. Writing 0 there leaves the flag unchanged.
- R9: Writing 1 to the restart bit zeroes the counter and the prescaler, so the next timeout is a full interval from that write.
- R10: The system reset input returns every field to its power-on value except the reset flag, which keeps its value. The power-on reset input also clears the reset flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | System reset, active low, keeps the reset flag |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq | output | 1 | Interrupt request level |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with divide ratios of 1, 2, 4 and 8, an interval base of 2^4 growing by a factor of 2 per select step, a reset delay of 8 ticks and a 4-cycle reset pulse. These small values let the bench run every clock select and every interval select through both timeout stages, down to the exact cycle, within a short run. The scaled ratios keep the property the shipping values have: every timeout is the tick count multiplied by a power-of-two divide. As a result, the off-by-one edges of the prescaler, the pause-and-resume accounting and the restart of a half-divided tick can all be observed cycle for cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int RESTART_BIT = 0;
   localparam int RST_EN_BIT  = 1;
   localparam int RFLAG_BIT   = 2;
   localparam int IFLAG_BIT   = 3;
   localparam int ISEL_LSB    = 4;
   localparam int INT_EN_BIT  = 6;
   localparam int EN_BIT      = 7;
   localparam int CSEL_LSB    = 10;
   localparam int USED_BITS   = 12;

   localparam int SEL_OPTS    = 4;

   typedef struct packed {
      logic [1:0] csel;
      logic       en;
      logic       int_en;
      logic [1:0] isel;
      logic       rst_en;
   } wdog_ctrl_t;

   localparam wdog_ctrl_t CTRL_RESET = '{csel: 2'd1, en: 1'b0, int_en: 1'b0,
                                          isel: 2'd0, rst_en: 1'b0};

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int DIV0_LOG2 = 0,
   parameter int DIV1_LOG2 = 8,
   parameter int DIV2_LOG2 = 11,
   parameter int DIV3_LOG2 = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       clr,
   input  logic [1:0] sel,
   output logic       tick
);
   import wdog_pkg::*;

   localparam int DL [SEL_OPTS] = '{DIV0_LOG2, DIV1_LOG2, DIV2_LOG2, DIV3_LOG2};

   function automatic int max_log2();
      int m = 0;
      for (int i = 0; i < SEL_OPTS; i++) if (DL[i] > m) m = DL[i];
      return m;
   endfunction

   localparam int PRE_W = max_log2() + 1;

   for (genvar g = 0; g < SEL_OPTS; g++) begin : g_chk
      if (DL[g] < 0 || DL[g] > 30) begin : g_bad_div
         $error("wdog_prescaler: divide log2 out of range");
      end
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask_opt [SEL_OPTS];

   for (genvar g = 0; g < SEL_OPTS; g++) begin : g_mask
      assign mask_opt[g] = PRE_W'((64'd1 << DL[g]) - 64'd1);
   end

   assign tick = en && ((pre_q & mask_opt[sel]) == mask_opt[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else if (en)  pre_q <= pre_q + PRE_W'(1);
   end

   // R9
   pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_q == '0));

   // R7
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W         = 22,
   parameter int INT_BASE_LOG2 = 14,
   parameter int INT_STEP_LOG2 = 2,
   parameter int RST_DELAY     = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       clr,
   input  logic [1:0] isel,
   output logic       int_hit,
   output logic       rst_hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] int_lim;
   logic [CNT_W-1:0] end_lim;
   logic             step;

   always_comb begin
      int_lim = CNT_W'(1) << (INT_BASE_LOG2 + INT_STEP_LOG2 * int'(isel));
      end_lim = int_lim + CNT_W'(RST_DELAY);
      cnt_inc = cnt_q + CNT_W'(1);
      step    = en && tick && !clr && (cnt_q < end_lim);
      int_hit = step && (cnt_inc == int_lim);
      rst_hit = step && (cnt_inc == end_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_inc;
   end

   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt_q));

   // R9
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic req
);
   localparam int PW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 2) begin : g_bad_len
      $error("wdog_pulse: PULSE_LEN must be at least 2");
   end

   logic [PW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req    <= 1'b0;
         left_q <= '0;
      end else if (trig) begin
         req    <= 1'b1;
         left_q <= PW'(PULSE_LEN - 1);
      end else if (req) begin
         if (left_q == '0) req <= 1'b0;
         else              left_q <= left_q - PW'(1);
      end
   end

   // R6
   pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |=> req);

   // R6
   pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> ($past(left_q) == '0));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int REG_OFFSET    = 'h1c,
   parameter int DIV0_LOG2     = 0,
   parameter int DIV1_LOG2     = 8,
   parameter int DIV2_LOG2     = 11,
   parameter int DIV3_LOG2     = 16,
   parameter int INT_BASE_LOG2 = 14,
   parameter int INT_STEP_LOG2 = 2,
   parameter int RST_DELAY     = 1024,
   parameter int RST_PULSE     = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              rst_req
);
   import wdog_pkg::*;

   localparam int MAX_EXP = INT_BASE_LOG2 + 3 * INT_STEP_LOG2;
   localparam int CNT_W   = MAX_EXP + 2;

   if (DATA_W < USED_BITS) begin : g_bad_data_w
      $error("wdog_timer: DATA_W too narrow for the control word");
   end
   if (MAX_EXP > 30) begin : g_bad_interval
      $error("wdog_timer: interval exponent too large");
   end
   if (RST_DELAY < 1 || RST_DELAY >= (1 << MAX_EXP)) begin : g_bad_delay
      $error("wdog_timer: RST_DELAY out of range");
   end
   if (REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
      $error("wdog_timer: REG_OFFSET does not fit ADDR_W");
   end

   logic       core_rst_n;
   wdog_ctrl_t ctrl_q;
   logic       iflag_q;
   logic       rflag_q;
   logic       addr_hit;
   logic       wr_hit;
   logic       restart;
   logic       tick;
   logic       int_hit;
   logic       rst_hit;
   logic       unused_wdata_hi;

   assign core_rst_n = por_n & rst_n;
   assign addr_hit   = bus_sel && (bus_addr == ADDR_W'(REG_OFFSET));
   assign wr_hit     = addr_hit && bus_wr;
   assign restart    = wr_hit && bus_wdata[RESTART_BIT];
   assign unused_wdata_hi = ^{bus_wdata[DATA_W-1:USED_BITS], bus_wdata[CSEL_LSB-1:EN_BIT+1]};

   // Control fields and interrupt flag: cleared by either reset
   always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) begin
         ctrl_q  <= CTRL_RESET;
         iflag_q <= 1'b0;
      end else begin
         if (wr_hit) begin
            ctrl_q.csel   <= bus_wdata[CSEL_LSB +: 2];
            ctrl_q.en     <= bus_wdata[EN_BIT];
            ctrl_q.int_en <= bus_wdata[INT_EN_BIT];
            ctrl_q.isel   <= bus_wdata[ISEL_LSB +: 2];
            ctrl_q.rst_en <= bus_wdata[RST_EN_BIT];
         end
         if (int_hit)                              iflag_q <= 1'b1;
         else if (wr_hit && bus_wdata[IFLAG_BIT])  iflag_q <= 1'b0;
      end
   end

   // Reset flag: only power-on clears it, so it survives the requested reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                   rflag_q <= 1'b0;
      else if (rst_hit && ctrl_q.rst_en)            rflag_q <= 1'b1;
      else if (wr_hit && bus_wdata[RFLAG_BIT])      rflag_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (addr_hit && !bus_wr) begin
         bus_rdata[CSEL_LSB +: 2] = ctrl_q.csel;
         bus_rdata[EN_BIT]        = ctrl_q.en;
         bus_rdata[INT_EN_BIT]    = ctrl_q.int_en;
         bus_rdata[ISEL_LSB +: 2] = ctrl_q.isel;
         bus_rdata[IFLAG_BIT]     = iflag_q;
         bus_rdata[RFLAG_BIT]     = rflag_q;
         bus_rdata[RST_EN_BIT]    = ctrl_q.rst_en;
      end
   end

   assign irq = iflag_q && ctrl_q.int_en;

   wdog_prescaler #(
      .DIV0_LOG2 (DIV0_LOG2),
      .DIV1_LOG2 (DIV1_LOG2),
      .DIV2_LOG2 (DIV2_LOG2),
      .DIV3_LOG2 (DIV3_LOG2)
   ) u_pre (
      .clk   (clk),
      .rst_n (core_rst_n),
      .en    (ctrl_q.en),
      .clr   (restart),
      .sel   (ctrl_q.csel),
      .tick  (tick)
   );

   wdog_counter #(
      .CNT_W         (CNT_W),
      .INT_BASE_LOG2 (INT_BASE_LOG2),
      .INT_STEP_LOG2 (INT_STEP_LOG2),
      .RST_DELAY     (RST_DELAY)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .en      (ctrl_q.en),
      .tick    (tick),
      .clr     (restart),
      .isel    (ctrl_q.isel),
      .int_hit (int_hit),
      .rst_hit (rst_hit)
   );

   wdog_pulse #(
      .PULSE_LEN (RST_PULSE)
   ) u_pulse (
      .clk   (clk),
      .rst_n (por_n),
      .trig  (rst_hit && ctrl_q.rst_en),
      .req   (rst_req)
   );

   // R3
   iflag_needs_en_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      $rose(iflag_q) |-> $past(ctrl_q.en));

   // R5
   rflag_needs_re_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
      $rose(rflag_q) |-> ctrl_q.rst_en);

   // R5
   req_with_rflag_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req) |-> rflag_q);

endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;

   localparam int BASE_TB   = 4;
   localparam int STEP_TB   = 1;
   localparam int DELAY_TB  = 8;
   localparam int PULSE_TB  = 4;
   localparam logic [7:0] REG_A = 8'h1c;

   localparam logic [31:0] EN_B  = 32'h80;
   localparam logic [31:0] IE_B  = 32'h40;
   localparam logic [31:0] IF_B  = 32'h08;
   localparam logic [31:0] RF_B  = 32'h04;
   localparam logic [31:0] RE_B  = 32'h02;
   localparam logic [31:0] RS_B  = 32'h01;

   // {clock select, interval select, interrupt enable, reset enable}
   localparam logic [5:0] VEC [8] = '{
      6'b00_00_1_1, 6'b01_01_0_1, 6'b10_10_1_0, 6'b11_11_1_1,
      6'b00_11_0_0, 6'b11_00_1_1, 6'b01_10_1_1, 6'b10_01_0_1
   };

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        rst_req;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   wdog_timer #(
      .DIV0_LOG2 (0), .DIV1_LOG2 (1), .DIV2_LOG2 (2), .DIV3_LOG2 (3),
      .INT_BASE_LOG2 (BASE_TB), .INT_STEP_LOG2 (STEP_TB),
      .RST_DELAY (DELAY_TB), .RST_PULSE (PULSE_TB)
   ) dut_i (
      .clk (clk), .por_n (por_n), .rst_n (rst_n),
      .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .irq (irq), .rst_req (rst_req)
   );

   function automatic int ratio(input logic [1:0] c);
      return 1 << int'(c);
   endfunction

   function automatic int interval(input logic [1:0] s);
      return 1 << (BASE_TB + STEP_TB * int'(s));
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      v = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic por_pulse();
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
   endtask

   task automatic sys_pulse();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [31:0] rv;
      @(negedge clk);
      por_pulse();

      // R1 reset state
      rd(REG_A, rv);
      chk("R1", "reset word", rv, 32'h400);
      chk("R1", "irq at reset", 32'(irq), 32'd0);
      chk("R1", "rst_req at reset", 32'(rst_req), 32'd0);

      // R1 other offsets
      wr(8'h18, 32'hFFFF_FFFF);
      rd(REG_A, rv);
      chk("R1", "write elsewhere ignored", rv, 32'h400);
      rd(8'h18, rv);
      chk("R1", "read elsewhere", rv, 32'd0);

      // Vector walk: R2..R6
      for (int v = 0; v < 8; v++) begin
         logic [1:0]  cs;
         logic [1:0]  is;
         logic        ie;
         logic        re;
         logic [31:0] cfg;
         int          m;
         int          d;
         int          n;
         {cs, is, ie, re} = VEC[v];
         m = interval(is) * ratio(cs);
         d = DELAY_TB * ratio(cs);
         cfg = (32'(cs) << 10) | EN_B | (ie ? IE_B : 32'd0) | (32'(is) << 4) |
               (re ? RE_B : 32'd0);
         por_pulse();
         wr(REG_A, cfg | RS_B);
         rd(REG_A, rv);
         chk("R2", "readback layout", rv, cfg);
         repeat (m - 1) @(negedge clk);
         rd(REG_A, rv);
         chk("R3", "iflag one cycle early", 32'(rv[3]), 32'd0);
         chk("R4", "irq one cycle early", 32'(irq), 32'd0);
         @(negedge clk);
         rd(REG_A, rv);
         chk("R3", "iflag at timeout", 32'(rv[3]), 32'd1);
         chk("R4", "irq at timeout", 32'(irq), 32'(ie));
         repeat (d - 1) @(negedge clk);
         rd(REG_A, rv);
         chk("R5", "rflag early", 32'(rv[2]), 32'd0);
         chk("R5", "rst_req early", 32'(rst_req), 32'd0);
         @(negedge clk);
         rd(REG_A, rv);
         chk("R5", "rflag at reset timeout", 32'(rv[2]), 32'(re));
         chk("R5", "rst_req at reset timeout", 32'(rst_req), 32'(re));
         if (re) begin
            n = 0;
            while (rst_req && n < 100) begin
               n++;
               @(negedge clk);
            end
            chk("R6", "pulse length", 32'(n), 32'(PULSE_TB));
         end
      end

      // R8 interrupt flag write-1-to-clear
      por_pulse();
      wr(REG_A, EN_B | IE_B | RS_B);
      repeat (16) @(negedge clk);
      wr(REG_A, EN_B | IE_B);
      rd(REG_A, rv);
      chk("R8", "iflag kept on write 0", rv, 32'hC8);
      wr(REG_A, EN_B | IE_B | IF_B);
      rd(REG_A, rv);
      chk("R8", "iflag cleared by write 1", rv, 32'hC0);
      chk("R8", "irq after clear", 32'(irq), 32'd0);

      // R7 pause and resume
      por_pulse();
      wr(REG_A, EN_B | IE_B | RS_B);
      repeat (7) @(negedge clk);
      wr(REG_A, IE_B);
      rd(REG_A, rv);
      chk("R7", "paused word", rv, 32'h40);
      repeat (100) @(negedge clk);
      rd(REG_A, rv);
      chk("R7", "no fire while paused", rv, 32'h40);
      chk("R7", "irq while paused", 32'(irq), 32'd0);
      wr(REG_A, EN_B | IE_B);
      repeat (7) @(negedge clk);
      rd(REG_A, rv);
      chk("R7", "resume not early", 32'(rv[3]), 32'd0);
      @(negedge clk);
      rd(REG_A, rv);
      chk("R7", "resume completes interval", rv, 32'hC8);
      chk("R7", "irq after resume", 32'(irq), 32'd1);

      // R9 restart mid-count with divide by 2
      por_pulse();
      wr(REG_A, (32'd1 << 10) | EN_B);
      repeat (5) @(negedge clk);
      wr(REG_A, (32'd1 << 10) | EN_B | RS_B);
      rd(REG_A, rv);
      chk("R9", "restart reads 0", rv, 32'h480);
      repeat (31) @(negedge clk);
      rd(REG_A, rv);
      chk("R9", "no fire before full interval", 32'(rv[3]), 32'd0);
      @(negedge clk);
      rd(REG_A, rv);
      chk("R9", "fire after full interval", 32'(rv[3]), 32'd1);

      // R10 sticky reset flag across system reset
      por_pulse();
      wr(REG_A, EN_B | IE_B | RE_B | RS_B);
      repeat (24) @(negedge clk);
      chk("R5", "rst_req with both enables", 32'(rst_req), 32'd1);
      sys_pulse();
      rd(REG_A, rv);
      chk("R10", "system reset keeps rflag", rv, 32'h404);
      chk("R10", "irq after system reset", 32'(irq), 32'd0);
      wr(REG_A, 32'h400 | RF_B);
      rd(REG_A, rv);
      chk("R8", "rflag cleared by write 1", rv, 32'h400);
      wr(REG_A, EN_B | RE_B | RS_B);
      repeat (24) @(negedge clk);
      por_pulse();
      rd(REG_A, rv);
      chk("R10", "power-on clears rflag", rv, 32'h400);

      finish_run();
   end

endmodule